// File: doc/BRIEF.md
# Cache bank request scheduler

Each clock cycle this block decides which request occupies the single pipeline slot of every cache bank. Three sources compete for a bank slot. A pending miss-queue replay has the highest priority. A returning memory fill comes next. Core requests from several input ports come last. Core requests are handled in ascending input order. A later request that targets the same set and tag with the same direction shares the slot through a free bank port. A request that cannot be placed is refused and stays with the requester, which retries it later. Requests marked as IO-space bypass the banks completely. They leave through a bypass channel, and their tag carries the input index. Responses on that channel are decoded back into an input index and the original tag.

The slot descriptors are registered, as are the bypass request, the decoded bypass response and two saturating stall counters. The accept signals to the core inputs and to the fill queues are combinational, so a requester knows in the same cycle whether to pop its request. Tag lookup, replacement and the memory side lie downstream and are not part of this block.

Top module: `bank_req_sched`

## Requirements
- R1: While `rst` is high at a clock edge, every slot kind becomes empty (0), all slot fields and port fields become 0, `byp_vld` and `rsp_vld` become 0, and both stall counters become 0.
- R2: A bank whose `rpl_vld` is high gets a replay slot (kind 2) at the next edge, carrying `rpl_write`, `rpl_set` and `rpl_tag`. Its fill is refused, and every non-IO core request to that bank that passes the miss-queue check is refused and counted as a bank stall.
- R3: A fill is accepted (`fill_rdy` high) only when its bank has no replay. The slot then becomes a fill (kind 1) with the fill id zero-extended into `slot_tag`, set 0 and write 0. A bank with neither a replay nor a fill and no placed core request is empty (kind 0) with all fields 0.
- R4: The bank of a core address is its low log2(NUM_BANKS) bits. The set is the next SET_W bits, and the tag is the remaining upper bits. The bank port of input i is i mod PORTS_PER_BANK.
- R5: A non-IO core request that reaches an empty slot is accepted. The slot becomes a core slot (kind 3) with the request's write flag, set and tag, and the request's port lane is valid with the input index and core tag.
- R6: A core request to a slot that already holds a core request is merged and accepted when the write flag, set and tag all match and its port lane is free.
- R7: A core request that hits a core slot with a mismatch or an occupied lane, or that hits a fill or replay slot, is refused and adds one to `bank_stalls`.
- R8: When a bank's `mshr_full` is high, a read to it, or a write to it while `wt_mode` is 0, is refused and adds one to both `bank_stalls` and `mshr_stalls`. A write while `wt_mode` is 1 skips this check.
- R9: Within a cycle, lower-numbered inputs are placed first, so on a conflict the lowest index wins.
- R10: At most one IO request is accepted per cycle, from the lowest-indexed valid IO input, and others are refused without counting a stall. At the next edge `byp_vld` rises with the request's address and write flag, and `byp_tag` equals core_tag times NUM_IN plus the input index.
- R11: A bypass response at one edge gives, at the next edge, `rsp_vld` high, `rsp_idx` equal to the low log2(NUM_IN) bits of `bypr_tag` and `rsp_tag` equal to the remaining upper bits.
- R12: Both stall counters saturate at their maximum value, and `mshr_stalls` never exceeds `bank_stalls`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 = write-through, writes skip the miss-queue check |
| core_vld | input | NUM_IN | Core request present per input |
| core_io | input | NUM_IN | Request targets IO space (bypass) |
| core_write | input | NUM_IN | Request is a write |
| core_addr | input | NUM_IN x ADDR_W | Request line address |
| core_tag | input | NUM_IN x CTAG_W | Requester tag |
| core_rdy | output | NUM_IN | Request accepted this cycle |
| rpl_vld | input | NUM_BANKS | Replay pending per bank |
| rpl_write | input | NUM_BANKS | Replay write flag |
| rpl_set | input | NUM_BANKS x SET_W | Replay set |
| rpl_tag | input | NUM_BANKS x TAG_W | Replay tag |
| fill_vld | input | NUM_BANKS | Fill response waiting per bank |
| fill_id | input | NUM_BANKS x FILL_ID_W | Miss-queue id of the fill |
| fill_rdy | output | NUM_BANKS | Fill accepted this cycle |
| mshr_full | input | NUM_BANKS | Bank miss queue has no free entry |
| slot_kind | output | NUM_BANKS x 2 | 0 empty, 1 fill, 2 replay, 3 core |
| slot_write | output | NUM_BANKS | Slot write flag |
| slot_set | output | NUM_BANKS x SET_W | Slot set |
| slot_tag | output | NUM_BANKS x TAG_W | Slot tag, or fill id |
| slot_pvld | output | NUM_BANKS x PORTS_PER_BANK | Port lane valid |
| slot_pid | output | NUM_BANKS x PORTS_PER_BANK x IDX_W | Input index per lane |
| slot_ptag | output | NUM_BANKS x PORTS_PER_BANK x CTAG_W | Core tag per lane |
| byp_vld | output | 1 | Bypass request valid |
| byp_write | output | 1 | Bypass request write flag |
| byp_addr | output | ADDR_W | Bypass request address |
| byp_tag | output | CTAG_W+IDX_W | Bypass tag carrying the input index |
| bypr_vld | input | 1 | Bypass response valid |
| bypr_tag | input | CTAG_W+IDX_W | Bypass response tag |
| rsp_vld | output | 1 | Decoded bypass response valid |
| rsp_idx | output | IDX_W | Destination input index |
| rsp_tag | output | CTAG_W | Recovered core tag |
| bank_stalls | output | CNT_W | Saturating bank stall count |
| mshr_stalls | output | CNT_W | Saturating miss-queue stall count |

## Verification
`core_rdy` and `fill_rdy` are combinational. They are due in the same cycle as the inputs, so the bench drives at the falling edge and samples them one nanosecond later, before the next rising edge. The slot descriptors, the bypass request, the decoded response and the stall counters each sit behind one register, so they are compared at the falling edge that follows the rising edge that captured them. A behavioural model in the bench computes both sets of values from the same drive every cycle. Directed sequences force lane conflicts, lane merging and counter saturation on top of a long random run.

// File: rtl/bsch_pkg.sv
`timescale 1ns/1ps
package bsch_pkg;

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_FILL   = 2'd1,
        SLOT_REPLAY = 2'd2,
        SLOT_CORE   = 2'd3
    } slot_kind_e;

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned sat_add(int unsigned cur, int unsigned inc,
                                            int unsigned top);
        return ((cur + inc) > top) ? top : (cur + inc);
    endfunction

endpackage

// File: rtl/bsch_addr_split.sv
`timescale 1ns/1ps
module bsch_addr_split #(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 2,
    parameter int SET_W     = 2,
    localparam int BANK_BITS = $clog2(NUM_BANKS),
    localparam int BANK_W    = bsch_pkg::width_of(NUM_BANKS),
    localparam int TAG_W     = ADDR_W - BANK_BITS - SET_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [SET_W-1:0]  set_idx,
    output logic [TAG_W-1:0]  tag
);
    generate
        if (NUM_BANKS > 1) begin : g_banked
            assign bank    = addr[BANK_BITS-1:0];
            assign set_idx = addr[BANK_BITS+SET_W-1:BANK_BITS];
            assign tag     = addr[ADDR_W-1:BANK_BITS+SET_W];
        end else begin : g_single
            assign bank    = '0;
            assign set_idx = addr[SET_W-1:0];
            assign tag     = addr[ADDR_W-1:SET_W];
        end
    endgenerate
endmodule

// File: rtl/bsch_bypass_codec.sv
`timescale 1ns/1ps
module bsch_bypass_codec #(
    parameter int NUM_IN = 4,
    parameter int CTAG_W = 8,
    localparam int IDX_W = bsch_pkg::width_of(NUM_IN),
    localparam int BT_W  = CTAG_W + IDX_W
) (
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [CTAG_W-1:0] req_ctag,
    output logic [BT_W-1:0]   req_btag,
    input  logic [BT_W-1:0]   rsp_btag,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [CTAG_W-1:0] rsp_ctag
);
    assign req_btag = {req_ctag, req_idx};
    assign rsp_idx  = rsp_btag[IDX_W-1:0];
    assign rsp_ctag = rsp_btag[BT_W-1:IDX_W];
endmodule

// File: rtl/bsch_slot_arbiter.sv
`timescale 1ns/1ps
module bsch_slot_arbiter
    import bsch_pkg::*;
#(
    parameter int NUM_IN         = 4,
    parameter int NUM_BANKS      = 2,
    parameter int PORTS_PER_BANK = 2,
    parameter int SET_W          = 2,
    parameter int TAG_W          = 9,
    parameter int CTAG_W         = 8,
    parameter int FILL_ID_W      = 3,
    localparam int BANK_W = width_of(NUM_BANKS),
    localparam int IDX_W  = width_of(NUM_IN),
    localparam int INC_W  = $clog2(NUM_IN + 1)
) (
    input  logic                                   wt_mode,
    input  logic [NUM_IN-1:0]                      in_vld,
    input  logic [NUM_IN-1:0]                      in_io,
    input  logic [NUM_IN-1:0]                      in_write,
    input  logic [NUM_IN-1:0][BANK_W-1:0]          in_bank,
    input  logic [NUM_IN-1:0][SET_W-1:0]           in_set,
    input  logic [NUM_IN-1:0][TAG_W-1:0]           in_tag,
    input  logic [NUM_IN-1:0][CTAG_W-1:0]          in_ctag,
    input  logic [NUM_BANKS-1:0]                   rpl_vld,
    input  logic [NUM_BANKS-1:0]                   rpl_write,
    input  logic [NUM_BANKS-1:0][SET_W-1:0]        rpl_set,
    input  logic [NUM_BANKS-1:0][TAG_W-1:0]        rpl_tag,
    input  logic [NUM_BANKS-1:0]                   fill_vld,
    input  logic [NUM_BANKS-1:0][FILL_ID_W-1:0]    fill_id,
    input  logic [NUM_BANKS-1:0]                   mshr_full,
    output logic [NUM_IN-1:0]                      in_rdy,
    output logic [NUM_BANKS-1:0]                   fill_rdy,
    output logic [NUM_BANKS-1:0][1:0]              nx_kind,
    output logic [NUM_BANKS-1:0]                   nx_write,
    output logic [NUM_BANKS-1:0][SET_W-1:0]        nx_set,
    output logic [NUM_BANKS-1:0][TAG_W-1:0]        nx_tag,
    output logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0] nx_pvld,
    output logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0][IDX_W-1:0]  nx_pid,
    output logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0][CTAG_W-1:0] nx_ptag,
    output logic                                   byp_sel_vld,
    output logic [IDX_W-1:0]                       byp_sel_idx,
    output logic [INC_W-1:0]                       bank_inc,
    output logic [INC_W-1:0]                       mshr_inc
);
    logic [BANK_W-1:0] b;
    int                p;

    always_comb begin
        // Stage 1: replay claims the slot, a fill takes it only if still empty.
        for (int k = 0; k < NUM_BANKS; k++) begin
            nx_pvld[k]  = '0;
            nx_pid[k]   = '0;
            nx_ptag[k]  = '0;
            fill_rdy[k] = 1'b0;
            if (rpl_vld[k]) begin
                nx_kind[k]  = SLOT_REPLAY;
                nx_write[k] = rpl_write[k];
                nx_set[k]   = rpl_set[k];
                nx_tag[k]   = rpl_tag[k];
            end else if (fill_vld[k]) begin
                nx_kind[k]  = SLOT_FILL;
                nx_write[k] = 1'b0;
                nx_set[k]   = '0;
                nx_tag[k]   = TAG_W'(fill_id[k]);
                fill_rdy[k] = 1'b1;
            end else begin
                nx_kind[k]  = SLOT_NONE;
                nx_write[k] = 1'b0;
                nx_set[k]   = '0;
                nx_tag[k]   = '0;
            end
        end

        // Stage 2: core inputs in ascending order.
        in_rdy      = '0;
        byp_sel_vld = 1'b0;
        byp_sel_idx = '0;
        bank_inc    = '0;
        mshr_inc    = '0;
        b           = '0;
        p           = 0;
        for (int i = 0; i < NUM_IN; i++) begin
            b = in_bank[i];
            p = i % PORTS_PER_BANK;
            if (in_vld[i]) begin
                if (in_io[i]) begin
                    if (!byp_sel_vld) begin
                        byp_sel_vld = 1'b1;
                        byp_sel_idx = IDX_W'(i);
                        in_rdy[i]   = 1'b1;
                    end
                end else if ((!in_write[i] || !wt_mode) && mshr_full[b]) begin
                    bank_inc = bank_inc + INC_W'(1);
                    mshr_inc = mshr_inc + INC_W'(1);
                end else if (nx_kind[b] == SLOT_CORE) begin
                    if (nx_write[b] == in_write[i] && nx_set[b] == in_set[i]
                        && nx_tag[b] == in_tag[i] && !nx_pvld[b][p]) begin
                        nx_pvld[b][p] = 1'b1;
                        nx_pid[b][p]  = IDX_W'(i);
                        nx_ptag[b][p] = in_ctag[i];
                        in_rdy[i]     = 1'b1;
                    end else begin
                        bank_inc = bank_inc + INC_W'(1);
                    end
                end else if (nx_kind[b] == SLOT_NONE) begin
                    nx_kind[b]    = SLOT_CORE;
                    nx_write[b]   = in_write[i];
                    nx_set[b]     = in_set[i];
                    nx_tag[b]     = in_tag[i];
                    nx_pvld[b][p] = 1'b1;
                    nx_pid[b][p]  = IDX_W'(i);
                    nx_ptag[b][p] = in_ctag[i];
                    in_rdy[i]     = 1'b1;
                end else begin
                    bank_inc = bank_inc + INC_W'(1);
                end
            end
        end
    end

    // R2: a bank holding a replay never accepts its fill in the same cycle
    always_comb begin
        for (int k = 0; k < NUM_BANKS; k++) begin
            a_r2_replay_blocks_fill: assert (!(rpl_vld[k] && fill_rdy[k]));
        end
    end

    // R10: never more than one IO request accepted per cycle
    always_comb begin
        a_r10_one_bypass: assert ($countones(in_rdy & in_io & in_vld) <= 1);
    end
endmodule

// File: rtl/bank_req_sched.sv
`timescale 1ns/1ps
module bank_req_sched
    import bsch_pkg::*;
#(
    parameter int NUM_IN         = 4,
    parameter int NUM_BANKS      = 2,
    parameter int PORTS_PER_BANK = 2,
    parameter int ADDR_W         = 12,
    parameter int SET_W          = 2,
    parameter int CTAG_W         = 8,
    parameter int FILL_ID_W      = 3,
    parameter int CNT_W          = 16,
    localparam int BANK_BITS = $clog2(NUM_BANKS),
    localparam int BANK_W    = width_of(NUM_BANKS),
    localparam int TAG_W     = ADDR_W - BANK_BITS - SET_W,
    localparam int IDX_W     = width_of(NUM_IN),
    localparam int BT_W      = CTAG_W + IDX_W,
    localparam int INC_W     = $clog2(NUM_IN + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   wt_mode,
    input  logic [NUM_IN-1:0]                      core_vld,
    input  logic [NUM_IN-1:0]                      core_io,
    input  logic [NUM_IN-1:0]                      core_write,
    input  logic [NUM_IN-1:0][ADDR_W-1:0]          core_addr,
    input  logic [NUM_IN-1:0][CTAG_W-1:0]          core_tag,
    output logic [NUM_IN-1:0]                      core_rdy,
    input  logic [NUM_BANKS-1:0]                   rpl_vld,
    input  logic [NUM_BANKS-1:0]                   rpl_write,
    input  logic [NUM_BANKS-1:0][SET_W-1:0]        rpl_set,
    input  logic [NUM_BANKS-1:0][TAG_W-1:0]        rpl_tag,
    input  logic [NUM_BANKS-1:0]                   fill_vld,
    input  logic [NUM_BANKS-1:0][FILL_ID_W-1:0]    fill_id,
    output logic [NUM_BANKS-1:0]                   fill_rdy,
    input  logic [NUM_BANKS-1:0]                   mshr_full,
    output logic [NUM_BANKS-1:0][1:0]              slot_kind,
    output logic [NUM_BANKS-1:0]                   slot_write,
    output logic [NUM_BANKS-1:0][SET_W-1:0]        slot_set,
    output logic [NUM_BANKS-1:0][TAG_W-1:0]        slot_tag,
    output logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0] slot_pvld,
    output logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0][IDX_W-1:0]  slot_pid,
    output logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0][CTAG_W-1:0] slot_ptag,
    output logic                                   byp_vld,
    output logic                                   byp_write,
    output logic [ADDR_W-1:0]                      byp_addr,
    output logic [BT_W-1:0]                        byp_tag,
    input  logic                                   bypr_vld,
    input  logic [BT_W-1:0]                        bypr_tag,
    output logic                                   rsp_vld,
    output logic [IDX_W-1:0]                       rsp_idx,
    output logic [CTAG_W-1:0]                      rsp_tag,
    output logic [CNT_W-1:0]                       bank_stalls,
    output logic [CNT_W-1:0]                       mshr_stalls
);
    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    typedef struct packed {
        logic              vld;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [BT_W-1:0]   tag;
    } byp_req_t;

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [CTAG_W-1:0] tag;
    } byp_rsp_t;

    logic [NUM_IN-1:0][BANK_W-1:0] dec_bank;
    logic [NUM_IN-1:0][SET_W-1:0]  dec_set;
    logic [NUM_IN-1:0][TAG_W-1:0]  dec_tag;

    generate
        for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_split
            bsch_addr_split #(
                .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .SET_W(SET_W)
            ) u_split (
                .addr(core_addr[gi]), .bank(dec_bank[gi]),
                .set_idx(dec_set[gi]), .tag(dec_tag[gi])
            );
        end
    endgenerate

    logic [NUM_BANKS-1:0][1:0]                                  nx_kind;
    logic [NUM_BANKS-1:0]                                       nx_write;
    logic [NUM_BANKS-1:0][SET_W-1:0]                            nx_set;
    logic [NUM_BANKS-1:0][TAG_W-1:0]                            nx_tag;
    logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0]                   nx_pvld;
    logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0][IDX_W-1:0]        nx_pid;
    logic [NUM_BANKS-1:0][PORTS_PER_BANK-1:0][CTAG_W-1:0]       nx_ptag;
    logic                                                       sel_vld;
    logic [IDX_W-1:0]                                           sel_idx;
    logic [INC_W-1:0]                                           bank_inc, mshr_inc;

    bsch_slot_arbiter #(
        .NUM_IN(NUM_IN), .NUM_BANKS(NUM_BANKS), .PORTS_PER_BANK(PORTS_PER_BANK),
        .SET_W(SET_W), .TAG_W(TAG_W), .CTAG_W(CTAG_W), .FILL_ID_W(FILL_ID_W)
    ) u_arb (
        .wt_mode(wt_mode), .in_vld(core_vld), .in_io(core_io),
        .in_write(core_write), .in_bank(dec_bank), .in_set(dec_set),
        .in_tag(dec_tag), .in_ctag(core_tag),
        .rpl_vld(rpl_vld), .rpl_write(rpl_write), .rpl_set(rpl_set),
        .rpl_tag(rpl_tag), .fill_vld(fill_vld), .fill_id(fill_id),
        .mshr_full(mshr_full), .in_rdy(core_rdy), .fill_rdy(fill_rdy),
        .nx_kind(nx_kind), .nx_write(nx_write), .nx_set(nx_set),
        .nx_tag(nx_tag), .nx_pvld(nx_pvld), .nx_pid(nx_pid), .nx_ptag(nx_ptag),
        .byp_sel_vld(sel_vld), .byp_sel_idx(sel_idx),
        .bank_inc(bank_inc), .mshr_inc(mshr_inc)
    );

    logic [BT_W-1:0]   sel_btag;
    logic [IDX_W-1:0]  dec_idx;
    logic [CTAG_W-1:0] dec_ctag;

    bsch_bypass_codec #(.NUM_IN(NUM_IN), .CTAG_W(CTAG_W)) u_codec (
        .req_idx(sel_idx), .req_ctag(core_tag[sel_idx]), .req_btag(sel_btag),
        .rsp_btag(bypr_tag), .rsp_idx(dec_idx), .rsp_ctag(dec_ctag)
    );

    byp_req_t byp_q;
    byp_rsp_t rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_kind   <= '0;
            slot_write  <= '0;
            slot_set    <= '0;
            slot_tag    <= '0;
            slot_pvld   <= '0;
            slot_pid    <= '0;
            slot_ptag   <= '0;
            byp_q       <= '0;
            rsp_q       <= '0;
            bank_stalls <= '0;
            mshr_stalls <= '0;
        end else begin
            slot_kind   <= nx_kind;
            slot_write  <= nx_write;
            slot_set    <= nx_set;
            slot_tag    <= nx_tag;
            slot_pvld   <= nx_pvld;
            slot_pid    <= nx_pid;
            slot_ptag   <= nx_ptag;
            byp_q       <= '{vld: sel_vld, write: core_write[sel_idx],
                             addr: core_addr[sel_idx], tag: sel_btag};
            rsp_q       <= '{vld: bypr_vld, idx: dec_idx, tag: dec_ctag};
            bank_stalls <= CNT_W'(sat_add(32'(bank_stalls), 32'(bank_inc), CNT_MAX));
            mshr_stalls <= CNT_W'(sat_add(32'(mshr_stalls), 32'(mshr_inc), CNT_MAX));
        end
    end

    assign byp_vld   = byp_q.vld;
    assign byp_write = byp_q.write;
    assign byp_addr  = byp_q.addr;
    assign byp_tag   = byp_q.tag;
    assign rsp_vld   = rsp_q.vld;
    assign rsp_idx   = rsp_q.idx;
    assign rsp_tag   = rsp_q.tag;

    // R12: miss-queue stalls are a subset of bank stalls
    a_r12_mshr_le_bank: assert property (@(posedge clk) disable iff (rst)
        mshr_stalls <= bank_stalls);

    // R11: a bypass response is decoded one edge later
    a_r11_rsp_decode: assert property (@(posedge clk) disable iff (rst)
        bypr_vld |=> (rsp_vld && rsp_idx == $past(bypr_tag[IDX_W-1:0])));

    generate
        for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank_chk
            // R2: replay owns the slot at the next edge
            a_r2_replay_slot: assert property (@(posedge clk) disable iff (rst)
                rpl_vld[gb] |=> (slot_kind[gb] == 2'd2 && slot_tag[gb] == $past(rpl_tag[gb])));
            // R5: a core slot always holds at least one port lane
            a_r5_core_has_lane: assert property (@(posedge clk) disable iff (rst)
                (slot_kind[gb] == 2'd3) |-> (|slot_pvld[gb]));
            for (genvar gp = 0; gp < PORTS_PER_BANK; gp++) begin : g_lane
                // R4: a lane only carries inputs that map to it
                a_r4_lane_map: assert property (@(posedge clk) disable iff (rst)
                    slot_pvld[gb][gp] |-> (int'(slot_pid[gb][gp]) % PORTS_PER_BANK == gp));
            end
        end
        for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in_chk
            // R8: full miss queue refuses reads and write-back writes
            a_r8_mshr_refuse: assert property (@(posedge clk) disable iff (rst)
                (core_vld[gi] && !core_io[gi]
                 && mshr_full[int'(core_addr[gi]) % NUM_BANKS]
                 && (!core_write[gi] || !wt_mode)) |-> !core_rdy[gi]);
        end
    endgenerate
endmodule

// File: tb/tb_bank_req_sched.sv
`timescale 1ns/1ps
module tb_bank_req_sched;
    localparam int NI = 4, NB = 2, PPB = 2, AW = 12, SW = 2, CW = 8, FW = 3, KW = 6;
    localparam int TW = AW - 1 - SW, IW = 2, BTW = CW + IW, CMAX = 63;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, wt_mode;
    logic [NI-1:0] core_vld, core_io, core_write, core_rdy;
    logic [NI-1:0][AW-1:0] core_addr;
    logic [NI-1:0][CW-1:0] core_tag;
    logic [NB-1:0] rpl_vld, rpl_write, fill_vld, fill_rdy, mshr_full;
    logic [NB-1:0][SW-1:0] rpl_set;
    logic [NB-1:0][TW-1:0] rpl_tag;
    logic [NB-1:0][FW-1:0] fill_id;
    logic [NB-1:0][1:0] slot_kind;
    logic [NB-1:0] slot_write;
    logic [NB-1:0][SW-1:0] slot_set;
    logic [NB-1:0][TW-1:0] slot_tag;
    logic [NB-1:0][PPB-1:0] slot_pvld;
    logic [NB-1:0][PPB-1:0][IW-1:0] slot_pid;
    logic [NB-1:0][PPB-1:0][CW-1:0] slot_ptag;
    logic byp_vld, byp_write, bypr_vld, rsp_vld;
    logic [AW-1:0] byp_addr;
    logic [BTW-1:0] byp_tag, bypr_tag;
    logic [IW-1:0] rsp_idx;
    logic [CW-1:0] rsp_tag;
    logic [KW-1:0] bank_stalls, mshr_stalls;

    bank_req_sched #(.NUM_IN(NI), .NUM_BANKS(NB), .PORTS_PER_BANK(PPB), .ADDR_W(AW),
        .SET_W(SW), .CTAG_W(CW), .FILL_ID_W(FW), .CNT_W(KW)) dut (
        .clk(clk), .rst(rst), .wt_mode(wt_mode), .core_vld(core_vld), .core_io(core_io),
        .core_write(core_write), .core_addr(core_addr), .core_tag(core_tag),
        .core_rdy(core_rdy), .rpl_vld(rpl_vld), .rpl_write(rpl_write), .rpl_set(rpl_set),
        .rpl_tag(rpl_tag), .fill_vld(fill_vld), .fill_id(fill_id), .fill_rdy(fill_rdy),
        .mshr_full(mshr_full), .slot_kind(slot_kind), .slot_write(slot_write),
        .slot_set(slot_set), .slot_tag(slot_tag), .slot_pvld(slot_pvld),
        .slot_pid(slot_pid), .slot_ptag(slot_ptag), .byp_vld(byp_vld),
        .byp_write(byp_write), .byp_addr(byp_addr), .byp_tag(byp_tag),
        .bypr_vld(bypr_vld), .bypr_tag(bypr_tag), .rsp_vld(rsp_vld), .rsp_idx(rsp_idx),
        .rsp_tag(rsp_tag), .bank_stalls(bank_stalls), .mshr_stalls(mshr_stalls));

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // reference model state and expectations
    int e_kind[NB], e_wr[NB], e_set[NB], e_tag[NB];
    int e_pv[NB][PPB], e_pid[NB][PPB], e_ptag[NB][PPB];
    int e_rdy[NI], e_frdy[NB];
    string e_why[NI];
    int e_bv, e_bw, e_ba, e_bt, e_rv, e_ri, e_rt;
    int m_bank = 0, m_mshr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model();
        int bk = 0, ms = 0, bsel = 0;
        for (int b = 0; b < NB; b++) begin
            e_frdy[b] = 0;
            for (int p = 0; p < PPB; p++) begin
                e_pv[b][p] = 0; e_pid[b][p] = 0; e_ptag[b][p] = 0;
            end
            if (rpl_vld[b]) begin
                e_kind[b] = 2; e_wr[b] = rpl_write[b];
                e_set[b] = rpl_set[b]; e_tag[b] = rpl_tag[b];
            end else if (fill_vld[b]) begin
                e_kind[b] = 1; e_wr[b] = 0; e_set[b] = 0; e_tag[b] = fill_id[b];
                e_frdy[b] = 1;
            end else begin
                e_kind[b] = 0; e_wr[b] = 0; e_set[b] = 0; e_tag[b] = 0;
            end
        end
        e_bv = 0; e_bw = 0; e_ba = 0; e_bt = 0;
        for (int i = 0; i < NI; i++) begin
            int a, b, s, t, p, w;
            e_rdy[i] = 0; e_why[i] = "R9";
            if (!core_vld[i]) continue;
            a = int'(core_addr[i]); b = a % NB; s = (a / NB) % 4; t = a / (NB * 4);
            p = i % PPB; w = core_write[i];
            if (core_io[i]) begin
                e_why[i] = "R10";
                if (!bsel) begin
                    bsel = 1; e_rdy[i] = 1;
                    e_bv = 1; e_bw = w; e_ba = a; e_bt = int'(core_tag[i]) * NI + i;
                end
            end else if ((!w || !wt_mode) && mshr_full[b]) begin
                e_why[i] = "R8"; bk++; ms++;
            end else if (e_kind[b] == 3) begin
                if (e_wr[b] == w && e_set[b] == s && e_tag[b] == t && !e_pv[b][p]) begin
                    e_why[i] = "R6"; e_rdy[i] = 1;
                    e_pv[b][p] = 1; e_pid[b][p] = i; e_ptag[b][p] = core_tag[i];
                end else begin
                    e_why[i] = "R7"; bk++;
                end
            end else if (e_kind[b] == 0) begin
                e_why[i] = "R5"; e_rdy[i] = 1;
                e_kind[b] = 3; e_wr[b] = w; e_set[b] = s; e_tag[b] = t;
                e_pv[b][p] = 1; e_pid[b][p] = i; e_ptag[b][p] = core_tag[i];
            end else begin
                e_why[i] = (e_kind[b] == 2) ? "R2" : "R7"; bk++;
            end
        end
        m_bank = (m_bank + bk > CMAX) ? CMAX : m_bank + bk;
        m_mshr = (m_mshr + ms > CMAX) ? CMAX : m_mshr + ms;
        e_rv = bypr_vld; e_ri = int'(bypr_tag) % NI; e_rt = int'(bypr_tag) / NI;
    endtask

    // inputs already driven after a falling edge
    task automatic cycle(input string rdy_req);
        model();
        #1;
        for (int i = 0; i < NI; i++)
            chk(core_rdy[i] == e_rdy[i][0], (rdy_req != "") ? rdy_req : e_why[i],
                $sformatf("core_rdy[%0d]", i), core_rdy[i], e_rdy[i]);
        for (int b = 0; b < NB; b++)
            chk(fill_rdy[b] == e_frdy[b][0], rpl_vld[b] ? "R2" : "R3",
                $sformatf("fill_rdy[%0d]", b), fill_rdy[b], e_frdy[b]);
        @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            string kr;
            kr = (e_kind[b] == 2) ? "R2" : (e_kind[b] == 3) ? "R5" : "R3";
            chk(int'(slot_kind[b]) == e_kind[b], kr, $sformatf("slot_kind[%0d]", b),
                slot_kind[b], e_kind[b]);
            chk(int'(slot_write[b]) == e_wr[b], kr, "slot_write", slot_write[b], e_wr[b]);
            chk(int'(slot_set[b]) == e_set[b], "R4", "slot_set", slot_set[b], e_set[b]);
            chk(int'(slot_tag[b]) == e_tag[b], "R4", "slot_tag", slot_tag[b], e_tag[b]);
            for (int p = 0; p < PPB; p++) begin
                chk(int'(slot_pvld[b][p]) == e_pv[b][p], "R6", "slot_pvld",
                    slot_pvld[b][p], e_pv[b][p]);
                chk(int'(slot_pid[b][p]) == e_pid[b][p], "R6", "slot_pid",
                    slot_pid[b][p], e_pid[b][p]);
                chk(int'(slot_ptag[b][p]) == e_ptag[b][p], "R6", "slot_ptag",
                    slot_ptag[b][p], e_ptag[b][p]);
            end
        end
        chk(int'(byp_vld) == e_bv, "R10", "byp_vld", byp_vld, e_bv);
        if (e_bv != 0) begin
            chk(int'(byp_write) == e_bw, "R10", "byp_write", byp_write, e_bw);
            chk(int'(byp_addr) == e_ba, "R10", "byp_addr", byp_addr, e_ba);
            chk(int'(byp_tag) == e_bt, "R10", "byp_tag", byp_tag, e_bt);
        end
        chk(int'(rsp_vld) == e_rv, "R11", "rsp_vld", rsp_vld, e_rv);
        if (e_rv != 0) begin
            chk(int'(rsp_idx) == e_ri, "R11", "rsp_idx", rsp_idx, e_ri);
            chk(int'(rsp_tag) == e_rt, "R11", "rsp_tag", rsp_tag, e_rt);
        end
        chk(int'(bank_stalls) == m_bank, "R7", "bank_stalls", bank_stalls, m_bank);
        chk(int'(mshr_stalls) == m_mshr, "R8", "mshr_stalls", mshr_stalls, m_mshr);
    endtask

    task automatic idle_inputs();
        core_vld = '0; core_io = '0; core_write = '0; core_addr = '0; core_tag = '0;
        rpl_vld = '0; rpl_write = '0; rpl_set = '0; rpl_tag = '0;
        fill_vld = '0; fill_id = '0; mshr_full = '0; bypr_vld = 1'b0; bypr_tag = '0;
    endtask

    function automatic logic [AW-1:0] mk_addr(int tag, int set, int bank);
        return AW'((tag << 3) | (set << 1) | bank);
    endfunction

    task automatic rand_inputs();
        for (int i = 0; i < NI; i++) begin
            core_vld[i]   = ($urandom % 4) != 0;
            core_io[i]    = ($urandom % 8) == 0;
            core_write[i] = ($urandom % 3) == 0;
            core_addr[i]  = mk_addr(($urandom % 2) ? 9'h0A5 : 9'h15A,
                                    $urandom % 2, $urandom % 2);
            core_tag[i]   = CW'($urandom);
        end
        for (int b = 0; b < NB; b++) begin
            rpl_vld[b]   = ($urandom % 6) == 0;
            rpl_write[b] = $urandom % 2;
            rpl_set[b]   = SW'($urandom);
            rpl_tag[b]   = TW'($urandom);
            fill_vld[b]  = ($urandom % 3) == 0;
            fill_id[b]   = FW'($urandom);
            mshr_full[b] = ($urandom % 5) == 0;
        end
        bypr_vld = ($urandom % 3) == 0;
        bypr_tag = BTW'($urandom);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wt_mode = 1'b0;
        idle_inputs();
        core_vld = '1; rpl_vld = '1; bypr_vld = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(slot_kind == '0, "R1", "slot_kind", slot_kind, 0);
        chk(slot_pvld == '0 && slot_tag == '0, "R1", "slot fields", slot_pvld, 0);
        chk(byp_vld == 1'b0, "R1", "byp_vld", byp_vld, 0);
        chk(rsp_vld == 1'b0, "R1", "rsp_vld", rsp_vld, 0);
        chk(bank_stalls == '0 && mshr_stalls == '0, "R1", "counters", bank_stalls, 0);
        rst = 1'b0;
        idle_inputs();
        cycle("");

        // R4/R5: a single read lands in its decoded bank and set
        idle_inputs();
        core_vld[3] = 1'b1; core_addr[3] = mk_addr(9'h1C3, 2, 1); core_tag[3] = 8'h5E;
        cycle("R5");
        chk(slot_kind[1] == 2'd3 && slot_set[1] == 2'd2, "R4", "decoded set", slot_set[1], 2);
        chk(slot_tag[1] == 9'h1C3 && slot_pvld[1] == 2'b10, "R4", "decoded tag/lane",
            slot_tag[1], 9'h1C3);

        // R6: inputs 0 and 1 share bank 1 through both lanes
        idle_inputs();
        core_vld[0] = 1'b1; core_vld[1] = 1'b1;
        core_addr[0] = mk_addr(9'h033, 1, 1); core_addr[1] = mk_addr(9'h033, 1, 1);
        core_tag[0] = 8'h11; core_tag[1] = 8'h22;
        cycle("R6");

        // R9: inputs 0 and 2 compete for lane 0 of bank 0; input 0 wins
        idle_inputs();
        core_vld[0] = 1'b1; core_vld[2] = 1'b1;
        core_addr[0] = mk_addr(9'h044, 0, 0); core_addr[2] = mk_addr(9'h044, 0, 0);
        cycle("R9");

        // R8: write-through write ignores a full miss queue, read does not
        idle_inputs();
        wt_mode = 1'b1; mshr_full = 2'b11;
        core_vld[0] = 1'b1; core_write[0] = 1'b1; core_addr[0] = mk_addr(9'h010, 0, 0);
        core_vld[1] = 1'b1; core_addr[1] = mk_addr(9'h010, 0, 1);
        cycle("R8");
        wt_mode = 1'b0;

        // R10: two IO requests, only the lowest goes out
        idle_inputs();
        core_vld = 4'b1010; core_io = 4'b1010; core_tag[1] = 8'hA7; core_tag[3] = 8'h3C;
        core_addr[1] = 12'hF0F;
        cycle("R10");

        // R12: saturate both counters
        for (int k = 0; k < 20; k++) begin
            idle_inputs();
            core_vld = '1; mshr_full = 2'b01;
            cycle("R8");
        end
        chk(bank_stalls == 6'd63, "R12", "bank_stalls saturated", bank_stalls, 63);
        chk(mshr_stalls == 6'd63, "R12", "mshr_stalls saturated", mshr_stalls, 63);

        // reset counters, then random traffic
        rst = 1'b1; idle_inputs();
        @(posedge clk); @(negedge clk);
        rst = 1'b0; m_bank = 0; m_mshr = 0;
        for (int c = 0; c < 4000; c++) begin
            if (c % 500 == 0) wt_mode = ~wt_mode;
            rand_inputs();
            cycle("");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule